// File: doc/BRIEF.md
# Hysteretic Power-Mode State Controller

This block sequences a supply with three rails. One rail is always on. The other two rails can be switched. On every clock the block reads four voltage codes, each in millivolts: the back-up rail, the main supply, the always-on rail output and a control voltage. It also reads an in-regulation flag for each switchable rail and a load-dump flag. From these it moves through seven modes: power off, power up, reset, wake, sleep, coma and on.

Most of the moves are driven by the single control voltage. That voltage is compared with different thresholds depending on the direction it is moving, so a slowly drifting input cannot make the mode chatter. After a fresh power-up the switchable rails stay off. They can only be enabled once the control voltage has first climbed high enough to reach the reset mode and has then been brought back down.

The outputs are:
- enables for the two switchable rails and for the always-on rail;
- a high-current select for the always-on rail;
- a reset line for a host processor;
- a hold line that is high only while everything is in regulation;
- the current mode as a 3-bit code.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rstN` is low at a clock edge, the next mode is power off (`modeCode` = 0), and the supply trigger is cleared.
- R2: In power off, the mode moves to power up (`modeCode` = 1) when `buMv` > 7900. At exactly 7900 it stays in power off. In power up, `rstOut`=1, `aonEn`=1, `aonHiCur`=1 and both rail enables are 0.
- R3: When `aonMv` < 3000, the next mode is power off, whatever the current mode and whatever the other inputs. In power off, every enable, `rstOut` and `holdOut` are 0.
- R4: In power up, `ctlMv` > 3800 leads to coma (5), and otherwise `ctlMv` > 2200 leads to reset (2). Power up never leads to on, even when `ctlMv` is low.
- R5: Reset (2) moves to wake (3) when `ctlMv` > 2800. Wake returns to reset when `ctlMv` < 1900.
- R6: Wake moves to sleep (4) when `ctlMv` > 3600. Sleep returns to wake when `ctlMv` < 2700.
- R7: Sleep moves to coma (5) when `ctlMv` > 3800. Coma returns to sleep when `ctlMv` < 3800. At exactly 3800 the mode stays in coma.
- R8: Reset moves to on (6) when all of these hold: `ctlMv` < 1100, `supMv` > 7600 and `loadDump` is 0. On returns to reset when `ctlMv` > 2000 or `supMv` < 7100.
- R9: The outputs depend on the mode as follows.
  - Sleep and coma: `aonEn`=1, `aonHiCur`=0, rail enables 0, `rstOut`=0.
  - Wake: `aonEn`=1, `aonHiCur`=1, rail enables 0, `rstOut`=0.
  - Reset: `aonEn`=1, `aonHiCur`=1, rail enables 0, `rstOut`=1.
  - On: `aonEn`=1, `aonHiCur`=1, both rail enables 1, `rstOut`=1.
- R10: The supply trigger is a registered comparator. It sets when `supMv` ≥ 7600, clears when `supMv` < 7100, and holds its value in between. Its new value takes effect on the clock edge after the sample.
- R11: `holdOut` is 1 only when all of these hold: the mode is on, the supply trigger is set, `buMv` ≥ 6000, `rail1Good` and `rail2Good` are 1, and `loadDump` is 0. It follows the flag inputs in the same cycle, without a clock delay.
- R12: While `loadDump` is 1:
  - both rail enables and `rstOut` are forced to 0 in the same cycle;
  - `aonEn` keeps its value for the current mode;
  - the mode itself is not changed by the load dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| buMv | input | 16 | Back-up rail code, mV |
| supMv | input | 16 | Main supply code, mV |
| aonMv | input | 16 | Always-on rail output code, mV |
| ctlMv | input | 16 | Control voltage code, mV |
| rail1Good | input | 1 | Switchable rail 1 in regulation |
| rail2Good | input | 1 | Switchable rail 2 in regulation |
| loadDump | input | 1 | Load-dump event flag |
| aonEn | output | 1 | Always-on rail enable |
| aonHiCur | output | 1 | Always-on rail high-current select |
| rail1En | output | 1 | Switchable rail 1 enable |
| rail2En | output | 1 | Switchable rail 2 enable |
| rstOut | output | 1 | Reset line to host |
| holdOut | output | 1 | Hold line (all good) |
| modeCode | output | 3 | Current mode, 0..6 |

## Verification
Three kinds of event can land in the same cycle as an ordinary control-voltage move: a collapse of the always-on rail, a load dump, and a control-voltage level that would otherwise lead to on.

Each collision is set up in one cycle, and the result is judged against the priority rules:
- The control voltage is put above the coma threshold while the always-on rail collapses. The expected next mode is power off, not coma.
- A load dump is raised in reset while the control voltage and the supply both satisfy the conditions for on. The mode must stay in reset, with the reset line forced low.
- Power up is held with a low control voltage. It must never reach on.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_PWRUP = 3'd1,
    MODE_RST   = 3'd2,
    MODE_WAKE  = 3'd3,
    MODE_SLEEP = 3'd4,
    MODE_COMA  = 3'd5,
    MODE_ON    = 3'd6
  } mode_e;

  // Level flags produced by the datapath comparators.
  typedef struct packed {
    logic aonLost;      // always-on rail collapsed
    logic buArm;        // back-up high enough to start
    logic ctlPupExit;   // control above power-up exit
    logic ctlComa;      // control above coma entry
    logic ctlWakeUp;    // control above reset->wake
    logic ctlWakeDn;    // control below wake->reset
    logic ctlSleepUp;   // control above wake->sleep
    logic ctlSleepDn;   // control below sleep->wake
    logic ctlComaDn;    // control below coma->sleep
    logic ctlOnEnter;   // control below reset->on
    logic ctlOnExit;    // control above on->reset
    logic supOnEnter;   // supply above on entry
    logic supOnExit;    // supply below on exit
  } level_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic aonOn;
    logic hiCur;
    logic railsOn;
    logic rstHigh;
    logic holdArm;
  } strobe_t;

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int W               = 16,
  parameter int BU_ARM_MV       = 7900,
  parameter int BU_OK_MV        = 6000,
  parameter int AON_OFF_MV      = 3000,
  parameter int CTL_PUP_EXIT_MV = 2200,
  parameter int CTL_COMA_MV     = 3800,
  parameter int CTL_WAKE_UP_MV  = 2800,
  parameter int CTL_WAKE_DN_MV  = 1900,
  parameter int CTL_SLEEP_UP_MV = 3600,
  parameter int CTL_SLEEP_DN_MV = 2700,
  parameter int CTL_ON_ENTER_MV = 1100,
  parameter int CTL_ON_EXIT_MV  = 2000,
  parameter int SUP_SET_MV      = 7600,
  parameter int SUP_CLR_MV      = 7100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] buMv,
  input  logic [W-1:0] supMv,
  input  logic [W-1:0] aonMv,
  input  logic [W-1:0] ctlMv,
  input  logic         rail1Good,
  input  logic         rail2Good,
  input  logic         loadDump,
  input  strobe_t      strobe,
  output level_t       lvl,
  output logic         aonEn,
  output logic         aonHiCur,
  output logic         rail1En,
  output logic         rail2En,
  output logic         rstOut,
  output logic         holdOut
);

  localparam logic [W-1:0] BuArm     = W'(BU_ARM_MV);
  localparam logic [W-1:0] BuOk      = W'(BU_OK_MV);
  localparam logic [W-1:0] AonOff    = W'(AON_OFF_MV);
  localparam logic [W-1:0] PupExit   = W'(CTL_PUP_EXIT_MV);
  localparam logic [W-1:0] ComaLvl   = W'(CTL_COMA_MV);
  localparam logic [W-1:0] WakeUp    = W'(CTL_WAKE_UP_MV);
  localparam logic [W-1:0] WakeDn    = W'(CTL_WAKE_DN_MV);
  localparam logic [W-1:0] SleepUp   = W'(CTL_SLEEP_UP_MV);
  localparam logic [W-1:0] SleepDn   = W'(CTL_SLEEP_DN_MV);
  localparam logic [W-1:0] OnEnter   = W'(CTL_ON_ENTER_MV);
  localparam logic [W-1:0] OnExit    = W'(CTL_ON_EXIT_MV);
  localparam logic [W-1:0] SupSet    = W'(SUP_SET_MV);
  localparam logic [W-1:0] SupClr    = W'(SUP_CLR_MV);
  localparam int           NumRails  = 2;

  logic supTrig;
  logic [NumRails-1:0] railGood;
  logic [NumRails-1:0] railEnVec;

  // Threshold comparators
  always_comb begin
    lvl.aonLost    = aonMv <  AonOff;
    lvl.buArm      = buMv  >  BuArm;
    lvl.ctlPupExit = ctlMv >  PupExit;
    lvl.ctlComa    = ctlMv >  ComaLvl;
    lvl.ctlWakeUp  = ctlMv >  WakeUp;
    lvl.ctlWakeDn  = ctlMv <  WakeDn;
    lvl.ctlSleepUp = ctlMv >  SleepUp;
    lvl.ctlSleepDn = ctlMv <  SleepDn;
    lvl.ctlComaDn  = ctlMv <  ComaLvl;
    lvl.ctlOnEnter = ctlMv <  OnEnter;
    lvl.ctlOnExit  = ctlMv >  OnExit;
    lvl.supOnEnter = supMv >  SupSet;
    lvl.supOnExit  = supMv <  SupClr;
  end

  // Registered hysteretic supply trigger
  always_ff @(posedge clk) begin
    if (!rstN) begin
      supTrig <= 1'b0;
    end else if (supMv >= SupSet) begin
      supTrig <= 1'b1;
    end else if (supMv < SupClr) begin
      supTrig <= 1'b0;
    end
  end

  assign railGood = {rail2Good, rail1Good};

  // Per-rail enable, forced off during load dump
  for (genvar i = 0; i < NumRails; i++) begin : g_rail
    assign railEnVec[i] = strobe.railsOn & ~loadDump;
  end

  assign rail1En  = railEnVec[0];
  assign rail2En  = railEnVec[1];
  assign aonEn    = strobe.aonOn;
  assign aonHiCur = strobe.hiCur;
  assign rstOut   = strobe.rstHigh & ~loadDump;
  assign holdOut  = strobe.holdArm & supTrig & (buMv >= BuOk)
                  & (&railGood) & ~loadDump;

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  level_t  lvl,
  input  logic    loadDump,
  output mode_e   mode,
  output strobe_t strobe
);

  mode_e modeNext;

  always_comb begin
    modeNext = mode;
    if (lvl.aonLost) begin
      modeNext = MODE_OFF;
    end else begin
      unique case (mode)
        MODE_OFF:   if (lvl.buArm) modeNext = MODE_PWRUP;
        MODE_PWRUP: begin
          if (lvl.ctlComa)         modeNext = MODE_COMA;
          else if (lvl.ctlPupExit) modeNext = MODE_RST;
        end
        MODE_RST: begin
          if (lvl.ctlOnEnter && lvl.supOnEnter && !loadDump) modeNext = MODE_ON;
          else if (lvl.ctlWakeUp)                            modeNext = MODE_WAKE;
        end
        MODE_WAKE: begin
          if (lvl.ctlSleepUp)     modeNext = MODE_SLEEP;
          else if (lvl.ctlWakeDn) modeNext = MODE_RST;
        end
        MODE_SLEEP: begin
          if (lvl.ctlComa)         modeNext = MODE_COMA;
          else if (lvl.ctlSleepDn) modeNext = MODE_WAKE;
        end
        MODE_COMA:  if (lvl.ctlComaDn) modeNext = MODE_SLEEP;
        MODE_ON:    if (lvl.ctlOnExit || lvl.supOnExit) modeNext = MODE_RST;
        default:    modeNext = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mode <= MODE_OFF;
    else       mode <= modeNext;
  end

  // Mode decode into strobes
  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_OFF:   strobe = '0;
      MODE_PWRUP: begin strobe.aonOn = 1'b1; strobe.hiCur = 1'b1; strobe.rstHigh = 1'b1; end
      MODE_RST:   begin strobe.aonOn = 1'b1; strobe.hiCur = 1'b1; strobe.rstHigh = 1'b1; end
      MODE_WAKE:  begin strobe.aonOn = 1'b1; strobe.hiCur = 1'b1; end
      MODE_SLEEP: strobe.aonOn = 1'b1;
      MODE_COMA:  strobe.aonOn = 1'b1;
      MODE_ON: begin
        strobe.aonOn   = 1'b1;
        strobe.hiCur   = 1'b1;
        strobe.railsOn = 1'b1;
        strobe.rstHigh = 1'b1;
        strobe.holdArm = 1'b1;
      end
      default:    strobe = '0;
    endcase
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int W               = 16,
  parameter int BU_ARM_MV       = 7900,
  parameter int BU_OK_MV        = 6000,
  parameter int AON_OFF_MV      = 3000,
  parameter int CTL_PUP_EXIT_MV = 2200,
  parameter int CTL_COMA_MV     = 3800,
  parameter int CTL_WAKE_UP_MV  = 2800,
  parameter int CTL_WAKE_DN_MV  = 1900,
  parameter int CTL_SLEEP_UP_MV = 3600,
  parameter int CTL_SLEEP_DN_MV = 2700,
  parameter int CTL_ON_ENTER_MV = 1100,
  parameter int CTL_ON_EXIT_MV  = 2000,
  parameter int SUP_SET_MV      = 7600,
  parameter int SUP_CLR_MV      = 7100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] buMv,
  input  logic [W-1:0] supMv,
  input  logic [W-1:0] aonMv,
  input  logic [W-1:0] ctlMv,
  input  logic         rail1Good,
  input  logic         rail2Good,
  input  logic         loadDump,
  output logic         aonEn,
  output logic         aonHiCur,
  output logic         rail1En,
  output logic         rail2En,
  output logic         rstOut,
  output logic         holdOut,
  output logic [2:0]   modeCode
);

  level_t  lvl;
  strobe_t strobe;
  mode_e   mode;

  pwr_mode_dp #(
    .W(W), .BU_ARM_MV(BU_ARM_MV), .BU_OK_MV(BU_OK_MV), .AON_OFF_MV(AON_OFF_MV),
    .CTL_PUP_EXIT_MV(CTL_PUP_EXIT_MV), .CTL_COMA_MV(CTL_COMA_MV),
    .CTL_WAKE_UP_MV(CTL_WAKE_UP_MV), .CTL_WAKE_DN_MV(CTL_WAKE_DN_MV),
    .CTL_SLEEP_UP_MV(CTL_SLEEP_UP_MV), .CTL_SLEEP_DN_MV(CTL_SLEEP_DN_MV),
    .CTL_ON_ENTER_MV(CTL_ON_ENTER_MV), .CTL_ON_EXIT_MV(CTL_ON_EXIT_MV),
    .SUP_SET_MV(SUP_SET_MV), .SUP_CLR_MV(SUP_CLR_MV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .buMv(buMv), .supMv(supMv), .aonMv(aonMv), .ctlMv(ctlMv),
    .rail1Good(rail1Good), .rail2Good(rail2Good), .loadDump(loadDump),
    .strobe(strobe), .lvl(lvl),
    .aonEn(aonEn), .aonHiCur(aonHiCur), .rail1En(rail1En), .rail2En(rail2En),
    .rstOut(rstOut), .holdOut(holdOut)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rstN(rstN), .lvl(lvl), .loadDump(loadDump),
    .mode(mode), .strobe(strobe)
  );

  assign modeCode = mode;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int W               = 16,
  parameter int AON_OFF_MV      = 3000,
  parameter int CTL_ON_ENTER_MV = 1100
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] aonMv,
  input logic [W-1:0] ctlMv,
  input logic         rail1Good,
  input logic         rail2Good,
  input logic         loadDump,
  input logic         aonEn,
  input logic         rail1En,
  input logic         rail2En,
  input logic         rstOut,
  input logic         holdOut,
  input logic [2:0]   modeCode
);

  assert_reset_off_R1: assert property (@(posedge clk) !rstN |=> modeCode == 3'd0);

  assert_rail_lost_R3: assert property (@(posedge clk) disable iff (!rstN)
    (aonMv < W'(AON_OFF_MV)) |=> modeCode == 3'd0);

  assert_pwrup_no_on_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd1) |=> modeCode != 3'd6);

  assert_on_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd2 && ctlMv >= W'(CTL_ON_ENTER_MV)) |=> modeCode != 3'd6);

  assert_rails_on_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rail1En || rail2En) |-> (modeCode == 3'd6 && rail1En == rail2En));

  assert_off_dark_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd0) |-> (!aonEn && !rstOut && !holdOut));

  assert_hold_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    holdOut |-> (modeCode == 3'd6 && rail1Good && rail2Good && !loadDump));

  assert_dump_force_R12: assert property (@(posedge clk) disable iff (!rstN)
    loadDump |-> (!rail1En && !rail2En && !rstOut && (aonEn == (modeCode != 3'd0))));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .W(W), .AON_OFF_MV(AON_OFF_MV), .CTL_ON_ENTER_MV(CTL_ON_ENTER_MV)
) u_chk (
  .clk(clk), .rstN(rstN), .aonMv(aonMv), .ctlMv(ctlMv),
  .rail1Good(rail1Good), .rail2Good(rail2Good), .loadDump(loadDump),
  .aonEn(aonEn), .rail1En(rail1En), .rail2En(rail2En), .rstOut(rstOut),
  .holdOut(holdOut), .modeCode(modeCode)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] buMv = '0, supMv = '0, aonMv = '0, ctlMv = '0;
  logic        rail1Good = 1'b0, rail2Good = 1'b0, loadDump = 1'b0;
  logic        aonEn, aonHiCur, rail1En, rail2En, rstOut, holdOut;
  logic [2:0]  modeCode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [8:0] expQ[$];
  string      tagQ[$];

  int  mdlMode = 0;
  bit  mdlTrig = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .buMv(buMv), .supMv(supMv), .aonMv(aonMv), .ctlMv(ctlMv),
    .rail1Good(rail1Good), .rail2Good(rail2Good), .loadDump(loadDump),
    .aonEn(aonEn), .aonHiCur(aonHiCur), .rail1En(rail1En), .rail2En(rail2En),
    .rstOut(rstOut), .holdOut(holdOut), .modeCode(modeCode)
  );

  function automatic int nextMode(int m, int bu, int sup, int aon, int ctl, bit ld);
    if (aon < 3000) return 0;
    case (m)
      0: return (bu > 7900) ? 1 : 0;
      1: return (ctl > 3800) ? 5 : (ctl > 2200) ? 2 : 1;
      2: return (ctl < 1100 && sup > 7600 && !ld) ? 6 : (ctl > 2800) ? 3 : 2;
      3: return (ctl > 3600) ? 4 : (ctl < 1900) ? 2 : 3;
      4: return (ctl > 3800) ? 5 : (ctl < 2700) ? 3 : 4;
      5: return (ctl < 3800) ? 4 : 5;
      6: return (ctl > 2000 || sup < 7100) ? 2 : 6;
      default: return 0;
    endcase
  endfunction

  // Driver: apply stimulus at the falling edge, push the expected result for the next rising edge
  task automatic drive(input bit rn, input int bu, input int sup, input int aon, input int ctl,
                       input bit g1, input bit g2, input bit ld, input string tag);
    logic [8:0] e;
    bit aonE, hiC, rails, rst, hold;
    @(negedge clk);
    rstN = rn; buMv = 16'(bu); supMv = 16'(sup); aonMv = 16'(aon); ctlMv = 16'(ctl);
    rail1Good = g1; rail2Good = g2; loadDump = ld;
    if (!rn) begin
      mdlMode = 0; mdlTrig = 1'b0;
    end else begin
      mdlMode = nextMode(mdlMode, bu, sup, aon, ctl, ld);
      if (sup >= 7600) mdlTrig = 1'b1;
      else if (sup < 7100) mdlTrig = 1'b0;
    end
    aonE  = (mdlMode != 0);
    hiC   = (mdlMode == 1 || mdlMode == 2 || mdlMode == 3 || mdlMode == 6);
    rails = (mdlMode == 6) && !ld;
    rst   = (mdlMode == 1 || mdlMode == 2 || mdlMode == 6) && !ld;
    hold  = (mdlMode == 6) && mdlTrig && (bu >= 6000) && g1 && g2 && !ld;
    e = {3'(mdlMode), aonE, hiC, rails, rails, rst, hold};
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        logic [8:0] exp;
        logic [8:0] act;
        string tag;
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        act = {modeCode, aonEn, aonHiCur, rail1En, rail2En, rstOut, holdOut};
        checks++;
        if (act !== exp) begin
          failures++;
          $display("FAIL %s: got mode=%0d outs=%b expected mode=%0d outs=%b",
                   tag, act[8:6], act[5:0], exp[8:6], exp[5:0]);
        end
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
    drive(0, 9000, 14000, 5000, 500, 1, 1, 0, "R1 reset held");
    drive(1, 0, 0, 0, 0, 0, 0, 0, "R3 stays off with dead rail");
    drive(1, 7900, 14000, 5000, 500, 1, 1, 0, "R2 back-up at 7900 stays off");
    drive(1, 8000, 14000, 5000, 500, 1, 1, 0, "R2 enter power up");
    drive(1, 8000, 14000, 5000, 500, 1, 1, 0, "R4 power up holds at low control");
    drive(1, 8000, 14000, 5000, 2200, 1, 1, 0, "R4 power up at 2200 holds");
    drive(1, 8000, 14000, 5000, 2300, 1, 1, 0, "R4 power up to reset");
    drive(1, 8000, 14000, 5000, 500, 1, 1, 0, "R8 reset to on");
    drive(1, 8000, 14000, 5000, 500, 1, 0, 0, "R11 hold drops on rail2 fault");
    drive(1, 8000, 14000, 5000, 500, 1, 1, 0, "R11 hold high in on");
    drive(1, 5000, 14000, 5000, 500, 1, 1, 0, "R11 hold low with weak back-up");
    drive(1, 8000, 14000, 5000, 500, 1, 1, 1, "R12 load dump in on");
    drive(1, 8000, 7100, 5000, 500, 1, 1, 0, "R10 supply at 7100 keeps trigger");
    drive(1, 8000, 7000, 5000, 500, 1, 1, 0, "R8 on exits on low supply");
    drive(1, 8000, 7601, 5000, 500, 1, 1, 0, "R10 trigger set entering on");
    drive(1, 8000, 14000, 5000, 2000, 1, 1, 0, "R8 on holds at 2000");
    drive(1, 8000, 14000, 5000, 2100, 1, 1, 0, "R8 on to reset on control");
    drive(1, 8000, 14000, 5000, 500, 1, 1, 1, "R12 load dump blocks on entry");
    drive(1, 8000, 14000, 5000, 2800, 1, 1, 0, "R5 reset at 2800 holds");
    drive(1, 8000, 14000, 5000, 2900, 1, 1, 0, "R5 reset to wake");
    drive(1, 8000, 14000, 5000, 1900, 1, 1, 0, "R5 wake at 1900 holds");
    drive(1, 8000, 14000, 5000, 1800, 1, 1, 0, "R5 wake to reset");
    drive(1, 8000, 14000, 5000, 2900, 1, 1, 0, "R5 back to wake");
    drive(1, 8000, 14000, 5000, 3700, 1, 1, 0, "R6 wake to sleep");
    drive(1, 8000, 14000, 5000, 2700, 1, 1, 0, "R6 sleep at 2700 holds");
    drive(1, 8000, 14000, 5000, 2600, 1, 1, 0, "R6 sleep to wake");
    drive(1, 8000, 14000, 5000, 3700, 1, 1, 0, "R6 wake to sleep again");
    drive(1, 8000, 14000, 5000, 3900, 1, 1, 0, "R7 sleep to coma");
    drive(1, 8000, 14000, 5000, 3800, 1, 1, 0, "R7 coma at 3800 holds");
    drive(1, 8000, 14000, 5000, 3700, 1, 1, 1, "R9 coma to sleep under load dump");
    drive(1, 8000, 14000, 2900, 3900, 1, 1, 0, "R3 collapse beats coma entry");
    drive(1, 8000, 14000, 5000, 3900, 1, 1, 0, "R2 power up again");
    drive(1, 8000, 14000, 5000, 3900, 1, 1, 0, "R4 power up to coma");
    drive(1, 8000, 14000, 5000, 3900, 1, 1, 0, "R9 coma outputs");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule